// File: doc/BRIEF.md
# Register Bank with Up/Down Stack Pointer

This block is an eight-entry general register file for a small processor datapath. It has two combinational read ports and one synchronous write port. The highest entry also serves as the stack pointer. Software can still read and write that entry like any other register, so an ALU result can be stored into it.

Two extra control pins step the stack pointer by one on the next rising clock edge: one counts up and one counts down. The control unit drives the up pin when data leaves the stack and the down pin when data goes onto it. The pointer always names the empty slot at the top of the stack, and the stack can be placed anywhere in memory by loading this entry.

The current pointer value is also driven on a dedicated output, which can go straight to a memory address multiplexer. A synchronous reset loads the pointer with a value fixed by a parameter and clears every other entry. No port carries a stream, so every pin is a plain level signal with no valid/ready handshake.

Top module: `regbank_sp`

## Requirements
- R1: While `rst` is high at a rising edge, the stack pointer entry (index NUM_REGS-1, which is 7 by default) is loaded with parameter SP_RESET and every other entry is cleared to zero.
- R2: When `wr_en` is 1 at a rising edge, entry `wr_sel` takes `wr_data`, and no other general entry changes.
- R3: `rd_data_a` and `rd_data_b` show, without a clock edge, the entries picked by `rd_sel_a` and `rd_sel_b`. The two ports are independent of each other.
- R4: When `sp_inc` is 1 and `sp_dec` is 0, and no write targets index 7, the stack pointer increases by one at the next rising edge.
- R5: When `sp_dec` is 1 and `sp_inc` is 0, and no write targets index 7, the stack pointer decreases by one at the next rising edge.
- R6: Counting wraps modulo 2^DATA_W. Stepping up from all ones gives zero, and stepping down from zero gives all ones.
- R7: When `sp_inc` and `sp_dec` are both 1 and no write targets index 7, the stack pointer keeps its value.
- R8: A write to index 7 takes priority over counting in the same cycle. The pointer takes `wr_data` whatever `sp_inc` and `sp_dec` are.
- R9: `sp_addr` always equals the stack pointer entry, which is also the value a read port returns for index 7.
- R10: Counting changes only the stack pointer. A write to another entry in the same cycle as counting takes effect as well.
- R11: When `wr_en` is 0 and both step controls are 0, no entry changes at the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable for the write port |
| wr_sel | input | SEL_W | Index of the entry to write |
| wr_data | input | DATA_W | Data to write |
| rd_sel_a | input | SEL_W | Index for read port A |
| rd_data_a | output | DATA_W | Read port A data |
| rd_sel_b | input | SEL_W | Index for read port B |
| rd_data_b | output | DATA_W | Read port B data |
| sp_inc | input | 1 | Step the stack pointer up by one |
| sp_dec | input | 1 | Step the stack pointer down by one |
| sp_addr | output | DATA_W | Current stack pointer, for memory addressing |

## Verification
The bench builds the block with DATA_W = 4, NUM_REGS = 8 and SP_RESET = 4'hC. A 4-bit pointer has only 16 values, so the bench can preload every one of them. From each value it applies all 64 combinations of up, down, write enable and write index. This covers wrap-around at both ends, the cases where the two step controls cancel, and the cases where a write collides with counting. After each step the bench reads every entry through both read ports and compares it, and the pointer output, against a model computed modulo 16.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Action applied to the stack pointer entry at the next edge
  typedef enum logic [1:0] {
    SP_HOLD = 2'd0,
    SP_LOAD = 2'd1,
    SP_UP   = 2'd2,
    SP_DOWN = 2'd3
  } sp_op_e;

endpackage

// File: rtl/rb_sp_ctrl.sv
module rb_sp_ctrl
  import regbank_pkg::*;
(
  input  logic   wr_hit,
  input  logic   step_up,
  input  logic   step_down,
  output sp_op_e op
);

  // Priority: write first, then a single step; opposing steps cancel.
  always_comb begin
    if (wr_hit)                       op = SP_LOAD;
    else if (step_up && !step_down)   op = SP_UP;
    else if (step_down && !step_up)   op = SP_DOWN;
    else                              op = SP_HOLD;
  end

endmodule

// File: rtl/rb_sp_reg.sv
module rb_sp_reg
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  sp_op_e            op,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RESET_VAL;
    end else begin
      unique case (op)
        SP_LOAD: q <= d;
        SP_UP:   q <= q + ONE;
        SP_DOWN: q <= q - ONE;
        default: q <= q;
      endcase
    end
  end

endmodule

// File: rtl/rb_gp_reg.sv
module rb_gp_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/rb_rd_mux.sv
module rb_rd_mux #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] entries,
  input  logic [SEL_W-1:0]                sel,
  output logic [DATA_W-1:0]               data
);

  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel == SEL_W'(i)) data = entries[i];
    end
  end

endmodule

// File: rtl/regbank_sp.sv
module regbank_sp
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8,
  parameter logic [DATA_W-1:0] SP_RESET = '0,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [SEL_W-1:0]  rd_sel_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              sp_inc,
  input  logic              sp_dec,
  output logic [DATA_W-1:0] sp_addr
);

  localparam int unsigned SP_IDX = NUM_REGS - 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] entry_q;
  logic [NUM_REGS-1:0]             entry_we;
  sp_op_e                          sp_op;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      entry_we[i] = wr_en && (wr_sel == SEL_W'(i));
    end
  end

  rb_sp_ctrl u_sp_ctrl (
    .wr_hit    (entry_we[SP_IDX]),
    .step_up   (sp_inc),
    .step_down (sp_dec),
    .op        (sp_op)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    if (g == SP_IDX) begin : g_sp
      rb_sp_reg #(
        .DATA_W    (DATA_W),
        .RESET_VAL (SP_RESET)
      ) u_sp (
        .clk (clk),
        .rst (rst),
        .op  (sp_op),
        .d   (wr_data),
        .q   (entry_q[g])
      );
    end else begin : g_gp
      rb_gp_reg #(
        .DATA_W (DATA_W)
      ) u_gp (
        .clk (clk),
        .rst (rst),
        .we  (entry_we[g]),
        .d   (wr_data),
        .q   (entry_q[g])
      );
    end
  end

  rb_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_a (
    .entries (entry_q),
    .sel     (rd_sel_a),
    .data    (rd_data_a)
  );

  rb_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_b (
    .entries (entry_q),
    .sel     (rd_sel_b),
    .data    (rd_data_b)
  );

  assign sp_addr = entry_q[SP_IDX];

endmodule

// File: rtl/rb_sp_checker.sv
module rb_sp_checker #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 8,
  parameter logic [DATA_W-1:0] SP_RESET = '0,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [SEL_W-1:0]  rd_sel_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic              sp_inc,
  input logic              sp_dec,
  input logic [DATA_W-1:0] sp_addr
);

  localparam logic [SEL_W-1:0]  SP_SEL = SEL_W'(NUM_REGS - 1);
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

  logic sp_wr;
  assign sp_wr = wr_en && (wr_sel == SP_SEL);

  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> (sp_addr == SP_RESET));

  assert_step_up_R4: assert property (@(posedge clk) disable iff (rst)
    (sp_inc && !sp_dec && !sp_wr) |=> (sp_addr == DATA_W'($past(sp_addr) + ONE)));

  assert_step_down_R5: assert property (@(posedge clk) disable iff (rst)
    (sp_dec && !sp_inc && !sp_wr) |=> (sp_addr == DATA_W'($past(sp_addr) - ONE)));

  assert_cancel_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (sp_inc && sp_dec && !sp_wr) |=> $stable(sp_addr));

  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    sp_wr |=> (sp_addr == $past(wr_data)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !sp_inc && !sp_dec) |=> $stable(sp_addr));

  assert_port_matches_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_a == SP_SEL) |-> (rd_data_a == sp_addr));

endmodule

bind regbank_sp rb_sp_checker #(
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .SP_RESET (SP_RESET)
) u_sp_checker (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .rd_sel_a  (rd_sel_a),
  .rd_data_a (rd_data_a),
  .sp_inc    (sp_inc),
  .sp_dec    (sp_dec),
  .sp_addr   (sp_addr)
);

// File: tb/tb_regbank_sp.sv
module tb_regbank_sp;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 4;
  localparam int N    = 8;
  localparam int SW   = 3;
  localparam int MASK = (1 << W) - 1;
  localparam int SPR  = 12;
  localparam int SPI  = N - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [SW-1:0] wr_sel = '0;
  logic [W-1:0]  wr_data = '0;
  logic [SW-1:0] rd_sel_a = '0;
  logic [W-1:0]  rd_data_a;
  logic [SW-1:0] rd_sel_b = '0;
  logic [W-1:0]  rd_data_b;
  logic          sp_inc = 1'b0;
  logic          sp_dec = 1'b0;
  logic [W-1:0]  sp_addr;

  int checks = 0;
  int errors = 0;
  int model [N];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regbank_sp #(.DATA_W(W), .NUM_REGS(N), .SP_RESET(W'(SPR))) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a), .rd_sel_b(rd_sel_b),
    .rd_data_b(rd_data_b), .sp_inc(sp_inc), .sp_dec(sp_dec), .sp_addr(sp_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Read every entry through both ports; port B uses a reversed order
  task automatic scan(input string sp_req);
    for (int r = 0; r < N; r++) begin
      rd_sel_a = SW'(r);
      rd_sel_b = SW'(N - 1 - r);
      #1;
      if (r == SPI) check(sp_req, int'(rd_data_a), model[r]);
      else          check("R3/R10", int'(rd_data_a), model[r]);
      check("R3", int'(rd_data_b), model[N - 1 - r]);
    end
    check("R9", int'(sp_addr), model[SPI]);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 0; sp_inc = 0; sp_dec = 0;
    step();
    rst = 1'b0;
    for (int r = 0; r < N; r++) model[r] = 0;
    model[SPI] = SPR;
    scan("R1");
  endtask

  initial begin
    do_reset();

    for (int v = 0; v <= MASK; v++) begin
      for (int c = 0; c < 64; c++) begin
        bit inc, dec, we;
        int sel, dat;
        string req;
        // preload the stack pointer with v
        wr_en = 1; wr_sel = SW'(SPI); wr_data = W'(v); sp_inc = 0; sp_dec = 0;
        step();
        model[SPI] = v;
        inc = c[0]; dec = c[1]; we = c[2]; sel = c >> 3;
        dat = (v * 3 + c + 5) & MASK;
        wr_en = we; wr_sel = SW'(sel); wr_data = W'(dat);
        sp_inc = inc; sp_dec = dec;
        step();
        wr_en = 0; sp_inc = 0; sp_dec = 0;
        if (we && sel == SPI)      req = (inc || dec) ? "R8" : "R2";
        else if (inc && !dec)      req = (v == MASK) ? "R6" : "R4";
        else if (dec && !inc)      req = (v == 0) ? "R6" : "R5";
        else if (inc && dec)       req = "R7";
        else                       req = "R11";
        if (we) model[sel] = dat;
        if (!(we && sel == SPI)) begin
          if (inc && !dec) model[SPI] = (v + 1) & MASK;
          if (dec && !inc) model[SPI] = (v - 1) & MASK;
        end
        scan(req);
      end
    end

    // reset after activity returns to the initial state
    do_reset();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule